// File: doc/BRIEF.md
# Phase-Aligned Timestamp Timebase

This block is a free-running timestamp counter for a capture unit. On every clock edge the count register advances by one. It wraps from all ones to zero and flags each wrap with a one-cycle overflow pulse. A sync event loads a programmable phase value into the counter. The event can come from the external sync input, which is gated by its enable, or from a software strobe. A separate strobe clears the counter to zero so that intervals can be measured. The capture logic drives this strobe after each qualified event.

The block also builds a sync output, so that several timebases can be chained and kept aligned. A two-bit select sets what drives it: the accepted sync event passed on, the period-match event, or nothing. Every output is registered and lines up with the count value it belongs to.

Internally a four-state machine records the action taken at the last clock edge. ST_PHASED means a sync event loaded the phase value. ST_CLEARED means the delta strobe cleared the counter. ST_WRAPPED means the count rolled over from all ones. ST_RUN is a plain increment. On every edge the machine moves to the state for that edge's action. The priority is phase load, then clear, then wrap, then run. Any state can move to any other. Reset enters ST_RUN with the count at zero.

Top module: `phase_sync_timebase`

## Requirements
- R1: After reset the count is 0 and all pulse outputs are 0. With no sync and no clear, each rising clock edge adds 1 to the count.
- R2: When an increment takes the count from 32'hFFFFFFFF to 0, ovf_pulse is 1 for exactly the cycle in which the count shows 0. At all other times it is 0.
- R3: If sync_in and sync_in_en are both 1 at a clock edge, the count equals phase_val (sampled at that edge) in the next cycle.
- R4: If sync_in_en is 0, a sync_in pulse has no effect, and the count advances by 1 as normal.
- R5: If sw_sync is 1 at a clock edge, the count is loaded with phase_val, whatever the value of sync_in_en.
- R6: If delta_rst is 1 at a clock edge and no sync event is accepted, the count is 0 in the next cycle.
- R7: If a sync event is accepted at the same edge as delta_rst, the phase load wins, and the count equals phase_val.
- R8: prd_match is 1 in exactly those cycles where the new count equals period_val, as sampled at the edge that produced that count.
- R9: sync_out_sel selects the sync output. Code 2'd1 passes on the accepted sync event (external or software). It appears in the cycle where the count shows the phase value. Code 2'd2 outputs the period match, aligned with prd_match. Codes 2'd0 and 2'd3 hold sync_out at 0.
- R10: A phase load or a delta clear that sets the count to 0 while it was 32'hFFFFFFFF does not raise ovf_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External sync pulse |
| sync_in_en | input | 1 | Enables acceptance of sync_in |
| sw_sync | input | 1 | Software sync strobe, always accepted |
| delta_rst | input | 1 | Clears the counter (delta measurement) |
| phase_val | input | 32 | Value loaded on an accepted sync |
| period_val | input | 32 | Compare value for the period match |
| sync_out_sel | input | 2 | Sync output source: 0 off, 1 sync pass, 2 period match, 3 off |
| count | output | 32 | Timestamp count bus |
| ovf_pulse | output | 1 | One-cycle wrap indication |
| prd_match | output | 1 | Count-equals-period indication |
| sync_out | output | 1 | Chained sync output |

## Verification
The counter is driven through several input patterns:
- Free running, to confirm the increment.
- An external sync with the enable high and then with it low. Different phase values are used, so that a wrongly accepted pulse shows up in the count.
- A software sync with the enable low, to separate the two sync sources.
- A clear on its own and a clear together with a software sync, to show which action takes priority.
- A phase load just below the top of the range, followed by free counting, to exercise the wrap and its pulse. Loads and clears from all ones are applied too, to show that only a real increment flags a wrap.
- A period set a few counts ahead, run with each select code, to tell apart the pass-through, period-match and off settings of the sync output.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    localparam int unsigned TSB_SEL_W = 2;

    typedef enum logic [TSB_SEL_W-1:0] {
        SO_OFF     = 2'd0,
        SO_PASS    = 2'd1,
        SO_PRD     = 2'd2,
        SO_OFF_ALT = 2'd3
    } so_sel_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_PHASED  = 2'd1,
        ST_CLEARED = 2'd2,
        ST_WRAPPED = 2'd3
    } tb_state_e;

endpackage

// File: rtl/tsb_event_arb.sv
module tsb_event_arb
    import tsb_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             sync_in,
    input  logic             sync_in_en,
    input  logic             sw_sync,
    input  logic             delta_rst,
    input  logic [CNT_W-1:0] count,
    output logic             sync_accept,
    output tb_state_e        nxt_state
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    always_comb begin
        sync_accept = sw_sync | (sync_in & sync_in_en);
        if (sync_accept) begin
            nxt_state = ST_PHASED;
        end else if (delta_rst) begin
            nxt_state = ST_CLEARED;
        end else if (count == CNT_TOP) begin
            nxt_state = ST_WRAPPED;
        end else begin
            nxt_state = ST_RUN;
        end
    end

endmodule

// File: rtl/tsb_timer.sv
module tsb_timer
    import tsb_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tb_state_e        nxt_state,
    input  logic [CNT_W-1:0] phase_val,
    input  logic [CNT_W-1:0] period_val,
    output logic [CNT_W-1:0] count,
    output logic             prd_hit_next,
    output logic             prd_match,
    output logic             ovf_pulse
);

    tb_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             prd_q;

    always_comb begin
        unique case (nxt_state)
            ST_PHASED:  cnt_d = phase_val;
            ST_CLEARED: cnt_d = '0;
            ST_WRAPPED: cnt_d = '0;
            ST_RUN:     cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
            default:    cnt_d = cnt_q;
        endcase
        prd_hit_next = (cnt_d == period_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            prd_q   <= 1'b0;
        end else begin
            state_q <= nxt_state;
            cnt_q   <= cnt_d;
            prd_q   <= prd_hit_next;
        end
    end

    always_comb begin
        count     = cnt_q;
        prd_match = prd_q;
        ovf_pulse = (state_q == ST_WRAPPED);
    end

endmodule

// File: rtl/tsb_sync_out.sv
module tsb_sync_out
    import tsb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TSB_SEL_W-1:0] sel,
    input  logic                 sync_accept,
    input  logic                 prd_hit_next,
    output logic                 sync_out
);

    logic so_d;
    logic so_q;

    always_comb begin
        unique case (so_sel_e'(sel))
            SO_PASS:    so_d = sync_accept;
            SO_PRD:     so_d = prd_hit_next;
            SO_OFF:     so_d = 1'b0;
            SO_OFF_ALT: so_d = 1'b0;
            default:    so_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q <= 1'b0;
        end else begin
            so_q <= so_d;
        end
    end

    assign sync_out = so_q;

endmodule

// File: rtl/phase_sync_timebase.sv
module phase_sync_timebase
    import tsb_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_in,
    input  logic                 sync_in_en,
    input  logic                 sw_sync,
    input  logic                 delta_rst,
    input  logic [CNT_W-1:0]     phase_val,
    input  logic [CNT_W-1:0]     period_val,
    input  logic [TSB_SEL_W-1:0] sync_out_sel,
    output logic [CNT_W-1:0]     count,
    output logic                 ovf_pulse,
    output logic                 prd_match,
    output logic                 sync_out
);

    tb_state_e nxt_state;
    logic      sync_accept;
    logic      prd_hit_next;

    tsb_event_arb #(.CNT_W(CNT_W)) u_arb (
        .sync_in     (sync_in),
        .sync_in_en  (sync_in_en),
        .sw_sync     (sw_sync),
        .delta_rst   (delta_rst),
        .count       (count),
        .sync_accept (sync_accept),
        .nxt_state   (nxt_state)
    );

    tsb_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .nxt_state    (nxt_state),
        .phase_val    (phase_val),
        .period_val   (period_val),
        .count        (count),
        .prd_hit_next (prd_hit_next),
        .prd_match    (prd_match),
        .ovf_pulse    (ovf_pulse)
    );

    tsb_sync_out u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sync_out_sel),
        .sync_accept  (sync_accept),
        .prd_hit_next (prd_hit_next),
        .sync_out     (sync_out)
    );

endmodule

// File: rtl/tsb_checker.sv
module tsb_checker
    import tsb_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_in,
    input logic                 sync_in_en,
    input logic                 sw_sync,
    input logic                 delta_rst,
    input logic [CNT_W-1:0]     phase_val,
    input logic [CNT_W-1:0]     period_val,
    input logic [TSB_SEL_W-1:0] sync_out_sel,
    input logic [CNT_W-1:0]     count,
    input logic                 ovf_pulse,
    input logic                 prd_match,
    input logic                 sync_out
);

    logic armed;
    logic ld;

    assign ld = sw_sync | (sync_in & sync_in_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(ld) && !$past(delta_rst)) |-> (count == CNT_W'($past(count) + 1)));

    // R3 R5 R7
    phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ld)) |-> (count == $past(phase_val)));

    // R6
    delta_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(delta_rst && !ld)) |-> (count == '0));

    // R2
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0));

    // R10
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ovf_pulse) |-> (!$past(ld) && !$past(delta_rst)));

    // R8
    prd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && prd_match) |-> (count == $past(period_val)));

    // R9
    sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(sync_out_sel) == 2'd0 || $past(sync_out_sel) == 2'd3)) |-> !sync_out);

endmodule

bind phase_sync_timebase tsb_checker #(.CNT_W(CNT_W)) i_tsb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_in      (sync_in),
    .sync_in_en   (sync_in_en),
    .sw_sync      (sw_sync),
    .delta_rst    (delta_rst),
    .phase_val    (phase_val),
    .period_val   (period_val),
    .sync_out_sel (sync_out_sel),
    .count        (count),
    .ovf_pulse    (ovf_pulse),
    .prd_match    (prd_match),
    .sync_out     (sync_out)
);

// File: tb/test_phase_sync_timebase.sv
`timescale 1ns/1ps
module test_phase_sync_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b0;
    logic        sync_in_en = 1'b0;
    logic        sw_sync = 1'b0;
    logic        delta_rst = 1'b0;
    logic [31:0] phase_val = '0;
    logic [31:0] period_val = 32'd12345678;
    logic [1:0]  sync_out_sel = 2'd0;
    logic [31:0] count;
    logic        ovf_pulse;
    logic        prd_match;
    logic        sync_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    phase_sync_timebase i_phase_sync_timebase (
        .clk, .rst_n, .sync_in, .sync_in_en, .sw_sync, .delta_rst,
        .phase_val, .period_val, .sync_out_sel,
        .count, .ovf_pulse, .prd_match, .sync_out
    );

    // behavioural reference
    longint m_count = 0;
    bit     m_ovf = 0, m_prd = 0, m_so = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_count = 0; m_ovf = 0; m_prd = 0; m_so = 0;
        end else begin
            bit     take;
            longint nxt;
            take = sw_sync || (sync_in && sync_in_en);
            if (take)           nxt = longint'(phase_val);
            else if (delta_rst) nxt = 0;
            else                nxt = (m_count + 1) % 64'h1_0000_0000;
            m_ovf = !take && !delta_rst && (m_count == 64'hFFFF_FFFF);
            m_prd = (nxt == longint'(period_val));
            if (sync_out_sel == 2'd1)      m_so = take;
            else if (sync_out_sel == 2'd2) m_so = m_prd;
            else                           m_so = 0;
            m_count = nxt;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 model count", longint'(count), m_count);
            chk("R2 model ovf", longint'(ovf_pulse), longint'(m_ovf));
            chk("R8 model prd_match", longint'(prd_match), longint'(m_prd));
            chk("R9 model sync_out", longint'(sync_out), longint'(m_so));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        sync_in = 0; sw_sync = 0; delta_rst = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] prev;
        tick(); tick();
        // R1 reset state
        chk("R1 reset count", longint'(count), 0);
        chk("R1 reset ovf", longint'(ovf_pulse), 0);
        chk("R1 reset sync_out", longint'(sync_out), 0);
        rst_n = 1;
        tick();
        chk("R1 first increment", longint'(count), 1);
        repeat (4) tick();
        chk("R1 free run", longint'(count), 5);

        // R3 external sync accepted, R9 pass-through
        sync_out_sel = 2'd1; sync_in_en = 1; sync_in = 1; phase_val = 32'd1000;
        tick(); clear_strobes();
        chk("R3 ext sync load", longint'(count), 1000);
        chk("R9 pass sync_out", longint'(sync_out), 1);
        tick();
        chk("R9 pass sync_out drop", longint'(sync_out), 0);

        // R4 external sync ignored when disabled
        sync_in_en = 0; phase_val = 32'd5000; prev = count; sync_in = 1;
        tick(); clear_strobes();
        chk("R4 ignored sync count", longint'(count), longint'(prev) + 1);
        chk("R4 ignored sync_out", longint'(sync_out), 0);

        // R5 software sync with enable low
        phase_val = 32'd7000; sw_sync = 1;
        tick(); clear_strobes();
        chk("R5 sw sync load", longint'(count), 7000);

        // R6 delta clear
        tick(); delta_rst = 1;
        tick(); clear_strobes();
        chk("R6 delta clear", longint'(count), 0);
        chk("R6 no ovf on clear", longint'(ovf_pulse), 0);

        // R7 priority
        phase_val = 32'd42; delta_rst = 1; sw_sync = 1;
        tick(); clear_strobes();
        chk("R7 phase beats clear", longint'(count), 42);

        // R8 period match with sel=2
        sync_out_sel = 2'd2; period_val = 32'd50; phase_val = 32'd45; sw_sync = 1;
        tick(); clear_strobes();
        chk("R9 prd sel no pass", longint'(sync_out), 0);
        repeat (4) tick();
        chk("R8 before match", longint'(prd_match), 0);
        tick();
        chk("R8 match count", longint'(count), 50);
        chk("R8 prd_match high", longint'(prd_match), 1);
        chk("R9 prd sync_out", longint'(sync_out), 1);
        tick();
        chk("R8 prd_match single", longint'(prd_match), 0);

        // R2 wrap
        sync_out_sel = 2'd0; phase_val = 32'hFFFF_FFFD; sw_sync = 1;
        tick(); clear_strobes();
        tick(); tick();
        chk("R2 top count", longint'(count), 64'hFFFF_FFFF);
        chk("R2 no early ovf", longint'(ovf_pulse), 0);
        tick();
        chk("R2 wrap count", longint'(count), 0);
        chk("R2 wrap ovf", longint'(ovf_pulse), 1);
        tick();
        chk("R2 ovf single", longint'(ovf_pulse), 0);

        // R10 clear and load from all ones
        phase_val = 32'hFFFF_FFFF; sw_sync = 1;
        tick(); clear_strobes();
        delta_rst = 1;
        tick(); clear_strobes();
        chk("R10 clear from top", longint'(count), 0);
        chk("R10 clear no ovf", longint'(ovf_pulse), 0);
        phase_val = 32'hFFFF_FFFF; sw_sync = 1;
        tick(); phase_val = 32'd0;
        tick(); clear_strobes();
        chk("R10 load zero from top", longint'(count), 0);
        chk("R10 load no ovf", longint'(ovf_pulse), 0);

        // R9 code 3 is off
        sync_out_sel = 2'd3; sync_in_en = 1; sync_in = 1; phase_val = 32'd9;
        tick(); clear_strobes();
        chk("R3 ext sync again", longint'(count), 9);
        chk("R9 sel3 off", longint'(sync_out), 0);
        repeat (5) tick();

        finish_run();
    end

endmodule